// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a segmented address, a 16-bit selector paired with a 32-bit offset, into a 32-bit linear address. The selector names a descriptor in one of two tables held in memory: a global table or a local table. The base and limit of each table come in on ports from registers held outside this block. The block keeps a small direct-mapped cache of descriptors it has already decoded. When a lookup misses, it fetches the 8-byte descriptor with two 32-bit reads over a simple request/acknowledge read port. It then pulls out the segment base, the 20-bit limit and the 12 rights bits.

Each accepted request gets exactly one result pulse. A good result carries base plus offset as the linear address. When paging is off, that value is also flagged as the physical address. A result can instead carry a fault code:
- the selector points beyond the end of its table;
- the segment is marked absent, so software can bring it in;
- the offset runs past the segment limit.

Absent descriptors are never cached. After software has loaded the segment, the next access fetches the updated descriptor again.

Top module: `seg_xlate`

## Requirements
- R1: The selector is split as follows. Bits [15:3] are the descriptor index. Bit 2 picks the table: 1 is the local table, 0 is the global table. Bits [1:0] are the requested privilege, returned unchanged on `rpl_o` with the result.
- R2: A descriptor fetch issues two reads. The first read is at table base + index*8 and the second is at that address + 4. Each read holds `mem_rd_o` high with `mem_addr_o` stable until `mem_ack_i` is seen.
- R3: Descriptor layout: the first word is the 32-bit segment base. In the second word, bits [19:0] are the limit and bits [31:20] are the rights. Rights bit 7 (bit 27 of the second word) is the present flag. The rights are reported on `rights_o`.
- R4: On success, `fault_o` is 0 and `lin_addr_o` = segment base + offset. For example, base 00030000h with offset 00002000h gives 00032000h.
- R5: If the offset is greater than the zero-extended limit, `fault_o` is 3 and `lin_addr_o` is 0. An offset equal to the limit succeeds.
- R6: If the present flag is clear, `fault_o` is 2 and `lin_addr_o` is 0. Such a descriptor is not cached, so every access to it fetches it again.
- R7: If index*8+7 is greater than the chosen table's 16-bit limit, `fault_o` is 1 and `lin_addr_o` is 0, and no memory read is made. This check has priority over the other two faults, and the not-present check has priority over the limit check.
- R8: On a cache hit, `done_o` pulses in the cycle after acceptance and no read is made. On a miss, `done_o` pulses in the cycle after the second acknowledge. A request is accepted when `req_valid_i` and `ready_o` are both high, and `ready_o` is low while a fetch runs.
- R9: The cache is direct-mapped with ENTRIES slots. The slot number is the low log2(ENTRIES) bits of the index. The tag is the table bit plus the remaining index bits. A fetched present descriptor replaces whatever its slot held.
- R10: `phys_valid_o` goes high with a fault-free result only when `paging_en_i` was low at completion. When it is high, `phys_addr_o` equals `lin_addr_o`.
- R11: After reset, `done_o` and `mem_rd_o` are low, `ready_o` is high and every cache slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gdt_base_i | input | 32 | Global table base address |
| gdt_limit_i | input | 16 | Global table byte limit |
| ldt_base_i | input | 32 | Local table base address |
| ldt_limit_i | input | 16 | Local table byte limit |
| paging_en_i | input | 1 | Paging enabled; suppresses the physical address flag |
| req_valid_i | input | 1 | Translation request |
| sel_i | input | 16 | Segment selector |
| off_i | input | 32 | Offset within the segment |
| ready_o | output | 1 | Block can accept a request |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_data_i | input | 32 | Memory read data |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 2 | 0 ok, 1 table, 2 not present, 3 limit |
| lin_addr_o | output | 32 | Linear address, zero on fault |
| phys_valid_o | output | 1 | Physical address valid (paging off, no fault) |
| phys_addr_o | output | 32 | Physical address |
| rpl_o | output | 2 | Requested privilege of the selector |
| rights_o | output | 12 | Rights bits of the descriptor used |

## Verification
The bench builds the block with ENTRIES = 4. With only four slots, a sweep over 34 indices in both tables keeps forcing slot conflicts and evictions, and a reference tag model in the bench predicts each hit and miss. The global table limit is set to 255 and the local table limit to 127. This places indices 32, 33 and 16 through 33 beyond their table ends, so the table-fault path is exercised next to the last valid descriptors.

Each selector is driven with several offsets:
- zero or a small value;
- exactly the limit;
- the limit plus one;
- all ones.

Every fifth descriptor is marked absent. Read acknowledges are stalled for odd indices, which exercises the hold requirement on the read port.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TABLE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_LIMIT  = 2'd3
  } seg_fault_e;

  // Packed so that {second word, first word} maps straight onto it
  typedef struct packed {
    logic [11:0] rights;
    logic [19:0] limit;
    logic [31:0] base;
  } seg_desc_t;

  localparam int unsigned PRESENT_BIT = 7;
  localparam int unsigned SEL_IDX_W   = 13;

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_ti,
  input  logic [SEL_IDX_W-1:0] lk_idx,
  output logic                 lk_hit,
  output seg_desc_t            lk_desc,
  input  logic                 wr_en,
  input  logic                 wr_ti,
  input  logic [SEL_IDX_W-1:0] wr_idx,
  input  seg_desc_t            wr_desc
);

  localparam int unsigned SLOT_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W  = 1 + SEL_IDX_W - SLOT_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  seg_desc_t          dat_q [ENTRIES];

  logic [SLOT_W-1:0]  lk_slot, wr_slot;
  logic [TAG_W-1:0]   lk_tag, wr_tag;

  assign lk_slot = lk_idx[SLOT_W-1:0];
  assign lk_tag  = {lk_ti, lk_idx[SEL_IDX_W-1:SLOT_W]};
  assign wr_slot = wr_idx[SLOT_W-1:0];
  assign wr_tag  = {wr_ti, wr_idx[SEL_IDX_W-1:SLOT_W]};

  assign lk_hit  = vld_q[lk_slot] && (tag_q[lk_slot] == lk_tag);
  assign lk_desc = dat_q[lk_slot];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_slot == SLOT_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q[e] <= 1'b0;
      else if (slot_we) vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[e] <= wr_tag;
        dat_q[e] <= wr_desc;
      end
    end
  end

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_data_i,
  output logic        mem_rd_o,
  output logic [31:0] mem_addr_o,
  output logic        fill_valid,
  output seg_desc_t   fill_desc
);

  typedef enum logic [1:0] {FS_IDLE, FS_LO, FS_HI} fs_e;

  fs_e         st_q, st_d;
  logic [31:0] addr_q, addr_d;
  logic [31:0] lo_q;
  logic        lo_en;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    lo_en  = 1'b0;
    unique case (st_q)
      FS_IDLE: if (start) begin
        st_d   = FS_LO;
        addr_d = start_addr;
      end
      FS_LO: if (mem_ack_i) begin
        st_d   = FS_HI;
        addr_d = addr_q + 32'd4;
        lo_en  = 1'b1;
      end
      FS_HI: if (mem_ack_i) st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= mem_data_i;
  end

  assign mem_rd_o   = (st_q != FS_IDLE);
  assign mem_addr_o = addr_q;
  assign fill_valid = (st_q == FS_HI) && mem_ack_i;
  assign fill_desc  = {mem_data_i, lo_q};

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlate_pkg::*;
(
  input  seg_desc_t   desc,
  input  logic [31:0] offset,
  output seg_fault_e  fault,
  output logic [31:0] lin
);

  logic absent, over;

  assign absent = !desc.rights[PRESENT_BIT];
  assign over   = offset > {12'd0, desc.limit};
  assign lin    = desc.base + offset;

  always_comb begin
    if (absent)    fault = FLT_ABSENT;
    else if (over) fault = FLT_LIMIT;
    else           fault = FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] gdt_base_i,
  input  logic [15:0] gdt_limit_i,
  input  logic [31:0] ldt_base_i,
  input  logic [15:0] ldt_limit_i,
  input  logic        paging_en_i,
  input  logic        req_valid_i,
  input  logic [15:0] sel_i,
  input  logic [31:0] off_i,
  output logic        ready_o,
  output logic        mem_rd_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_data_i,
  output logic        done_o,
  output logic [1:0]  fault_o,
  output logic [31:0] lin_addr_o,
  output logic        phys_valid_o,
  output logic [31:0] phys_addr_o,
  output logic [1:0]  rpl_o,
  output logic [11:0] rights_o
);

  logic                 req_ti;
  logic [SEL_IDX_W-1:0] req_idx;
  logic [31:0]          tbl_base;
  logic [15:0]          tbl_lim;
  logic                 tbl_flt;
  logic                 accept, hit, start;
  seg_desc_t            hit_desc;

  logic [15:0]          sel_q;
  logic [31:0]          off_q;

  logic                 fill_valid;
  seg_desc_t            fill_desc;

  seg_desc_t            chk_desc;
  logic [31:0]          chk_off, chk_lin;
  seg_fault_e           chk_fault;

  logic                 done_d, pv_d;
  seg_fault_e           fault_d;
  logic [31:0]          lin_d;
  logic [1:0]           rpl_d;
  logic [11:0]          rights_d;

  logic                 done_q, pv_q;
  seg_fault_e           fault_q;
  logic [31:0]          lin_q;
  logic [1:0]           rpl_q;
  logic [11:0]          rights_q;

  // Selector decode and table choice
  assign req_ti   = sel_i[2];
  assign req_idx  = sel_i[15:3];
  assign tbl_base = req_ti ? ldt_base_i  : gdt_base_i;
  assign tbl_lim  = req_ti ? ldt_limit_i : gdt_limit_i;
  assign tbl_flt  = {req_idx, 3'b111} > tbl_lim;

  assign ready_o  = !mem_rd_o;
  assign accept   = req_valid_i && ready_o;
  assign start    = accept && !tbl_flt && !hit;

  always_ff @(posedge clk) begin
    if (accept) begin
      sel_q <= sel_i;
      off_q <= off_i;
    end
  end

  seg_desc_cache #(.ENTRIES(ENTRIES)) cache_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_ti   (req_ti),
    .lk_idx  (req_idx),
    .lk_hit  (hit),
    .lk_desc (hit_desc),
    .wr_en   (fill_valid && fill_desc.rights[PRESENT_BIT]),
    .wr_ti   (sel_q[2]),
    .wr_idx  (sel_q[15:3]),
    .wr_desc (fill_desc)
  );

  seg_fetch_ctrl fetch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (tbl_base + {16'd0, req_idx, 3'b000}),
    .mem_ack_i  (mem_ack_i),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .fill_valid (fill_valid),
    .fill_desc  (fill_desc)
  );

  // fill_valid only occurs while busy, accept only while idle
  assign chk_desc = fill_valid ? fill_desc : hit_desc;
  assign chk_off  = fill_valid ? off_q     : off_i;

  seg_limit_check check_i (
    .desc   (chk_desc),
    .offset (chk_off),
    .fault  (chk_fault),
    .lin    (chk_lin)
  );

  // Result next-state
  always_comb begin
    done_d   = fill_valid || (accept && (tbl_flt || hit));
    fault_d  = (accept && tbl_flt) ? FLT_TABLE : chk_fault;
    lin_d    = (fault_d == FLT_NONE) ? chk_lin : 32'd0;
    rpl_d    = fill_valid ? sel_q[1:0] : sel_i[1:0];
    rights_d = (fault_d == FLT_TABLE) ? 12'd0 : chk_desc.rights;
    pv_d     = done_d && (fault_d == FLT_NONE) && !paging_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      pv_q     <= 1'b0;
      fault_q  <= FLT_NONE;
      lin_q    <= '0;
      rpl_q    <= '0;
      rights_q <= '0;
    end else begin
      done_q <= done_d;
      pv_q   <= pv_d;
      if (done_d) begin
        fault_q  <= fault_d;
        lin_q    <= lin_d;
        rpl_q    <= rpl_d;
        rights_q <= rights_d;
      end
    end
  end

  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign lin_addr_o   = lin_q;
  assign phys_valid_o = pv_q;
  assign phys_addr_o  = lin_q;
  assign rpl_o        = rpl_q;
  assign rights_o     = rights_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        ready_o,
  input logic        mem_rd_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        done_o,
  input logic [1:0]  fault_o,
  input logic [31:0] lin_addr_o,
  input logic        phys_valid_o,
  input logic        paging_en_i
);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !ready_o);

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  // R8
  accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && ready_o) |=> (done_o || mem_rd_o));

  // R5
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o != 2'd0) |-> (lin_addr_o == 32'd0));

  // R10
  phys_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_valid_o |-> (done_o && fault_o == 2'd0));

  // R10
  paging_blocks_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && paging_en_i && $stable(paging_en_i)) |-> (!phys_valid_o || !$past(paging_en_i)));

endmodule

bind seg_xlate seg_xlate_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .ready_o      (ready_o),
  .mem_rd_o     (mem_rd_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .lin_addr_o   (lin_addr_o),
  .phys_valid_o (phys_valid_o),
  .paging_en_i  (paging_en_i)
);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

  localparam int NENT = 4;
  localparam logic [31:0] GBASE = 32'h0001_0000;
  localparam logic [31:0] LBASE = 32'h0002_0000;
  localparam logic [15:0] GLIM  = 16'h00FF;
  localparam logic [15:0] LLIM  = 16'h007F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [31:0] off_i = '0;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic        ready_o, mem_rd_o, done_o, phys_valid_o;
  logic [31:0] mem_addr_o, lin_addr_o, phys_addr_o;
  logic [1:0]  fault_o, rpl_o;
  logic [11:0] rights_o;

  int n_chk = 0;
  int n_fail = 0;

  bit          sh_v   [NENT];
  logic [11:0] sh_tag [NENT];

  always #2 clk = ~clk;

  seg_xlate #(.ENTRIES(NENT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .gdt_base_i(GBASE), .gdt_limit_i(GLIM),
    .ldt_base_i(LBASE), .ldt_limit_i(LLIM),
    .paging_en_i(paging_en_i),
    .req_valid_i(req_valid_i), .sel_i(sel_i), .off_i(off_i),
    .ready_o(ready_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i),
    .done_o(done_o), .fault_o(fault_o), .lin_addr_o(lin_addr_o),
    .phys_valid_o(phys_valid_o), .phys_addr_o(phys_addr_o),
    .rpl_o(rpl_o), .rights_o(rights_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Descriptor contents of the bench memory
  function automatic logic [31:0] d_base(input bit ti, input int idx);
    return 32'h0003_0000 + (ti ? 32'h0100_0000 : 32'h0) + (32'(idx) << 12);
  endfunction
  function automatic logic [19:0] d_lim(input int idx);
    return 20'h02000 + 20'(idx * 16);
  endfunction
  function automatic bit d_pres(input int idx);
    return (idx % 5) != 3;
  endfunction
  function automatic logic [11:0] d_rights(input int idx);
    return d_pres(idx) ? 12'h09A : 12'h01A;
  endfunction

  task automatic xlate(input bit ti, input int idx, input logic [31:0] off, input bit pg);
    logic [31:0] tb_base;
    logic [15:0] tb_lim;
    int          slot, reads, done_at, last_ack;
    bit          exp_tflt, exp_hit, stall, addr_ok, seen;
    logic [11:0] key;
    logic [1:0]  exp_flt;
    logic [31:0] exp_lin;
    logic [1:0]  rpl;

    rpl      = 2'(idx % 4);
    tb_base  = ti ? LBASE : GBASE;
    tb_lim   = ti ? LLIM : GLIM;
    exp_tflt = (idx * 8 + 7) > int'(tb_lim);
    slot     = idx % NENT;
    key      = {ti, 11'(idx / NENT)};
    exp_hit  = !exp_tflt && sh_v[slot] && sh_tag[slot] == key;
    if (exp_tflt)                          exp_flt = 2'd1;
    else if (!d_pres(idx))                 exp_flt = 2'd2;
    else if (off > {12'd0, d_lim(idx)})    exp_flt = 2'd3;
    else                                   exp_flt = 2'd0;
    exp_lin = (exp_flt == 2'd0) ? d_base(ti, idx) + off : 32'd0;

    chk("R8 ready before request", {31'd0, ready_o}, 32'd1);
    paging_en_i = pg;
    sel_i       = {13'(idx), ti, rpl};
    off_i       = off;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    sel_i       = 16'hFFFF;
    off_i       = 32'hDEAD_BEEF;

    reads = 0; done_at = -1; last_ack = -10; addr_ok = 1'b1; seen = 1'b0;
    stall = idx[0];
    for (int c = 0; c < 40; c++) begin
      if (done_o) begin done_at = c; seen = 1'b1; break; end
      if (mem_rd_o) begin
        if (stall) begin
          mem_ack_i = 1'b0;
          stall     = 1'b0;
        end else begin
          if (mem_addr_o !== tb_base + 32'(idx * 8) + 32'(reads * 4)) addr_ok = 1'b0;
          mem_ack_i  = 1'b1;
          mem_data_i = (reads == 0) ? d_base(ti, idx) : {d_rights(idx), d_lim(idx)};
          reads++;
          last_ack = c;
          stall    = idx[0];
        end
      end else begin
        mem_ack_i = 1'b0;
      end
      @(negedge clk);
    end
    mem_ack_i = 1'b0;

    chk("R8 result pulse seen", {31'd0, seen}, 32'd1);
    chk("R2 fetch addresses", {31'd0, addr_ok}, 32'd1);
    if (exp_tflt) begin
      chk("R7 no read on table fault", 32'(reads), 32'd0);
      chk("R7 table fault latency", 32'(done_at), 32'd0);
    end else if (exp_hit) begin
      chk("R8 hit makes no read", 32'(reads), 32'd0);
      chk("R8 hit latency", 32'(done_at), 32'd0);
    end else begin
      chk("R2 two reads on miss", 32'(reads), 32'd2);
      chk("R8 miss latency", 32'(done_at), 32'(last_ack + 1));
    end
    if (exp_tflt)           chk("R7 fault code", {30'd0, fault_o}, {30'd0, exp_flt});
    else if (exp_flt == 2)  chk("R6 fault code", {30'd0, fault_o}, {30'd0, exp_flt});
    else if (exp_flt == 3)  chk("R5 fault code", {30'd0, fault_o}, {30'd0, exp_flt});
    else                    chk("R4 fault code", {30'd0, fault_o}, 32'd0);
    chk("R4 linear address", lin_addr_o, exp_lin);
    chk("R1 rpl echo", {30'd0, rpl_o}, {30'd0, rpl});
    if (!exp_tflt) chk("R3 rights", {20'd0, rights_o}, {20'd0, d_rights(idx)});
    chk("R10 phys valid", {31'd0, phys_valid_o}, {31'd0, (exp_flt == 2'd0) && !pg});
    if (phys_valid_o) chk("R10 phys addr", phys_addr_o, exp_lin);

    // R9 / R6 reference tag model: only present descriptors are filled
    if (!exp_tflt && !exp_hit && d_pres(idx)) begin
      sh_v[slot]   = 1'b1;
      sh_tag[slot] = key;
    end
    @(negedge clk);
    chk("R8 single result pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NENT; s++) begin sh_v[s] = 1'b0; sh_tag[s] = '0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done low in reset", {31'd0, done_o}, 32'd0);
    chk("R11 mem read low in reset", {31'd0, mem_rd_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", {31'd0, ready_o}, 32'd1);

    // R4 worked example: global index 0, base 00030000h, offset 00002000h
    xlate(1'b0, 0, 32'h0000_2000, 1'b0);
    chk("R4 example address", lin_addr_o, 32'h0003_2000);

    for (int pass = 0; pass < 2; pass++) begin
      for (int t = 0; t < 2; t++) begin
        for (int idx = 0; idx < 34; idx++) begin
          bit pg;
          pg = idx[1];
          xlate(t[0], idx, 32'(idx * 3), pg);
          xlate(t[0], idx, {12'd0, d_lim(idx)}, pg);          // R5 boundary ok
          xlate(t[0], idx, {12'd0, d_lim(idx)} + 32'd1, pg);  // R5 just over
          xlate(t[0], idx, 32'hFFFF_FFFF, !pg);
        end
      end
    end

    // R9 conflict: same slot, other table evicts, then original misses again
    xlate(1'b0, 4, 32'd0, 1'b0);
    xlate(1'b1, 4, 32'd0, 1'b0);
    xlate(1'b0, 4, 32'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule